// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control and slot status registers of a downstream port that can support hot-plug. Software reaches both through a small configuration port with an address, a write strobe and write data. Reads are combinational. A write to the control register can become a hot-plug command. The block passes that command to a downstream slot controller over a valid/ready handshake that carries the new 16-bit register value. The slot controller later pulses a done input. When that done pulse arrives, the block sets the command-completed status bit.

The `strict_mode` input selects how writes become commands. In strict mode, every control write on a port that can hot-plug is a command. In legacy mode, a write is a command only when it changes at least one of the indicator, power or interlock control fields. Writes that touch only the other bits update the register but are never announced as commands. When `hp_capable` is low, no write ever becomes a command.

Top module: `hp_slot_ctl`

## Requirements
- R1: After reset, the control register reads 0x0000, the status register reads 0x0000, and `cmd_valid` is low.
- R2: The control register sits at address 0xA8 and stores all 16 written bits. The status register sits at address 0xAA. Status bit 4 is command-completed and bit 15 is busy-overlap; all other status bits read 0. Any other address reads 0. `cfg_rdata` follows `cfg_addr` in the same cycle.
- R3: In strict mode (`strict_mode`=1), with `hp_capable`=1, every control write to an idle block raises `cmd_valid` on the next cycle, and `cmd_data` equals the written value.
- R4: In legacy mode (`strict_mode`=0), a control write is a command only if it changes bits [11:6]. These bits are the attention indicator [7:6], power indicator [9:8], power controller [10] and interlock [11]. A write that leaves those bits unchanged issues no command and never sets status bit 4, even when it changes other bits.
- R5: With `hp_capable`=0, control writes update the register but issue no command and never set status bit 4.
- R6: Once `cmd_valid` is high, it stays high with a stable `cmd_data` until `cmd_ready` is seen. Status bit 4 rises only on the cycle after `cmd_done` is sampled while the accepted command is outstanding. A `cmd_done` that arrives while no command is outstanding is ignored.
- R7: Status bits 4 and 15 are write-1-to-clear. Writing 0 to them leaves them unchanged. If a set and a clear fall in the same cycle, the bit ends up set.
- R8: A command-generating write made while a command is still outstanding is stored in the register and sets status bit 15. After the outstanding `cmd_done`, exactly one follow-up command is issued, carrying the latest register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_capable | input | 1 | Port supports hot-plug commands |
| strict_mode | input | 1 | 1: every write is a command; 0: only field-changing writes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| cmd_valid | output | 1 | Command offered to slot controller |
| cmd_ready | input | 1 | Slot controller accepts the command |
| cmd_data | output | 16 | Control register value carried by the command |
| cmd_done | input | 1 | One-cycle pulse: slot controller finished the command |

## Verification
The embedded assertions watch the handshake on every cycle. They check that the offer is held with stable data, that completion rises only after a done pulse for an outstanding command, and that write-1-to-clear works. They also check that an idle block starts no command on legacy no-change writes or on a port without hot-plug support, and that a strict-mode write is offered with its own data. Other properties need whole scenarios, which the bench provides: the per-write table across mode, capability and field changes, the set-beats-clear collision, a stray done while idle, and the follow-up command after an overlapping write.

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 16,
  parameter logic [11:0] CTL_ADDR = 12'hA8,
  parameter logic [11:0] STS_ADDR = 12'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_capable,
  input  logic              strict_mode,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_done
);
  localparam int CC_BIT  = 4;
  localparam int OVL_BIT = 15;
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(16'h0FC0);

  typedef enum logic [1:0] {S_IDLE, S_OFFER, S_WAIT} st_t;

  st_t              st;
  logic [DATA_W-1:0] ctl_q, cmd_q;
  logic              cc_q, ovl_q, again_q;

  logic wr_ctl, wr_sts, fields_chg, new_cmd, busy, done_ok;
  logic [DATA_W-1:0] ctl_nxt, sts_val;

  assign wr_ctl     = cfg_wr && (cfg_addr == ADDR_W'(CTL_ADDR));
  assign wr_sts     = cfg_wr && (cfg_addr == ADDR_W'(STS_ADDR));
  assign ctl_nxt    = wr_ctl ? cfg_wdata : ctl_q;
  assign fields_chg = |((cfg_wdata ^ ctl_q) & FIELD_MASK);
  assign new_cmd    = wr_ctl && hp_capable && (strict_mode || fields_chg);
  assign busy       = (st != S_IDLE);
  assign done_ok    = (st == S_WAIT) && cmd_done;

  always_comb begin
    sts_val          = '0;
    sts_val[CC_BIT]  = cc_q;
    sts_val[OVL_BIT] = ovl_q;
  end

  assign cfg_rdata = (cfg_addr == ADDR_W'(CTL_ADDR)) ? ctl_q :
                     (cfg_addr == ADDR_W'(STS_ADDR)) ? sts_val : '0;
  assign cmd_valid = (st == S_OFFER);
  assign cmd_data  = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctl_q   <= '0;
      cmd_q   <= '0;
      cc_q    <= 1'b0;
      ovl_q   <= 1'b0;
      again_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      cc_q  <= (cc_q  & ~(wr_sts & cfg_wdata[CC_BIT]))  | done_ok;
      ovl_q <= (ovl_q & ~(wr_sts & cfg_wdata[OVL_BIT])) | (new_cmd & busy);
      case (st)
        S_IDLE: if (new_cmd) begin
          st    <= S_OFFER;
          cmd_q <= cfg_wdata;
        end
        S_OFFER: begin
          if (cmd_ready) st <= S_WAIT;
          if (new_cmd) again_q <= 1'b1;
        end
        S_WAIT: begin
          if (cmd_done) begin
            if (again_q || new_cmd) begin
              st      <= S_OFFER;
              cmd_q   <= ctl_nxt;
              again_q <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else if (new_cmd) begin
            again_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  a_r6_cc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_q) |-> $past(cmd_done) && $past(st == S_WAIT));

  a_r6_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && !cc_q |=> !cc_q);

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && cfg_wdata[CC_BIT] && !done_ok |=> !cc_q);

  a_r5_no_cmd_uncapable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && wr_ctl && !hp_capable |=> !cmd_valid);

  a_r4_legacy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && wr_ctl && !strict_mode && !fields_chg |=> !cmd_valid);

  a_r3_strict_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && wr_ctl && hp_capable && strict_mode
    |=> cmd_valid && (cmd_data == $past(cfg_wdata)));
endmodule

// File: tb/hp_slot_ctl_bench.sv
module hp_slot_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DONE_DLY   = 4;
  localparam logic [11:0] A_CTL = 12'hA8;
  localparam logic [11:0] A_STS = 12'hAA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hp_capable = 1'b1, strict_mode = 1'b1;
  logic cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata, cmd_data;
  logic cmd_valid, cmd_ready = 1'b1;
  logic auto_on = 1'b1, auto_done = 1'b0, man_done = 1'b0;
  logic cmd_done;
  int   dly_cnt = 0;
  int   n_acc = 0;
  logic [15:0] last_acc = '0;
  int   checks = 0, failures = 0;

  assign cmd_done = auto_done | man_done;

  hp_slot_ctl u_hp_slot_ctl (
    .clk(clk), .rst_n(rst_n), .hp_capable(hp_capable), .strict_mode(strict_mode),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_done(cmd_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      n_acc    <= n_acc + 1;
      last_acc <= cmd_data;
    end
    auto_done <= 1'b0;
    if (auto_on) begin
      if (dly_cnt != 0) begin
        dly_cnt <= dly_cnt - 1;
        if (dly_cnt == 1) auto_done <= 1'b1;
      end else if (cmd_valid && cmd_ready) begin
        dly_cnt <= DONE_DLY;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {strict, capable, expect_cmd, data}; legacy commands need a change in bits [11:6]
  localparam logic [18:0] VEC [12] = '{
    {1'b1, 1'b1, 1'b1, 16'h0000},
    {1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 16'h003F},
    {1'b0, 1'b1, 1'b1, 16'h00BF},
    {1'b0, 1'b1, 1'b0, 16'h00BF},
    {1'b0, 1'b1, 1'b1, 16'h04BF},
    {1'b0, 1'b1, 1'b1, 16'h0CBF},
    {1'b0, 1'b1, 1'b1, 16'h0DBF},
    {1'b0, 1'b1, 1'b0, 16'hFDBF},
    {1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b0, 16'h0FC0},
    {1'b1, 1'b1, 1'b1, 16'h0FC0}
  };

  initial begin
    logic [15:0] r;
    int base;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTL, r); chk("R1 ctl reset", r, 16'h0000);
        rd(A_STS, r); chk("R1 sts reset", r, 16'h0000);
        chk("R1 cmd_valid reset", cmd_valid, 0);

        for (int v = 0; v < 12; v++) begin
          strict_mode = VEC[v][18];
          hp_capable  = VEC[v][17];
          wr(A_STS, 16'h8010);
          base = n_acc;
          wr(A_CTL, VEC[v][15:0]);
          idle(12);
          rd(A_CTL, r); chk($sformatf("R2 vec%0d readback", v), r, VEC[v][15:0]);
          chk($sformatf("R3/R4/R5 vec%0d cmd count", v), n_acc - base, {31'd0, VEC[v][16]});
          rd(A_STS, r);
          chk($sformatf("R4/R5/R6 vec%0d completed", v), r[4], VEC[v][16]);
          if (VEC[v][16]) chk($sformatf("R3 vec%0d cmd data", v), last_acc, VEC[v][15:0]);
        end

        rd(12'hA4, r); chk("R2 unmapped read", r, 16'h0000);
        hp_capable = 1'b1; strict_mode = 1'b1;
        wr(A_STS, 16'h0000);
        rd(A_STS, r); chk("R7 write-0 keeps completed", r, 16'h0010);
        wr(A_STS, 16'h0010);
        rd(A_STS, r); chk("R7 w1c clears completed", r, 16'h0000);

        // R6: held offer while not ready
        cmd_ready = 1'b0;
        wr(A_CTL, 16'h1234);
        idle(5);
        chk("R6 offer held", cmd_valid, 1);
        chk("R6 offer data", cmd_data, 16'h1234);
        rd(A_STS, r); chk("R6 no completion before delivery", r[4], 0);
        cmd_ready = 1'b1;
        idle(DONE_DLY + 3);
        rd(A_STS, r); chk("R6 completion after done", r[4], 1);

        // R6: stray done while idle
        wr(A_STS, 16'h0010);
        @(negedge clk); man_done = 1'b1;
        @(negedge clk); man_done = 1'b0;
        idle(2);
        rd(A_STS, r); chk("R6 stray done ignored", r[4], 0);

        // R7: set wins over clear in the same cycle
        auto_on = 1'b0;
        wr(A_CTL, 16'h0040);
        idle(3);
        cfg_wr = 1'b1; cfg_addr = A_STS; cfg_wdata = 16'h0010; man_done = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; man_done = 1'b0;
        rd(A_STS, r); chk("R7 set wins over clear", r[4], 1);
        auto_on = 1'b1;
        wr(A_STS, 16'h8010);

        // R8: overlapping command
        base = n_acc;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = A_CTL; cfg_wdata = 16'h0100;
        @(negedge clk);
        cfg_wdata = 16'h0200;
        @(negedge clk);
        cfg_wr = 1'b0;
        idle(2 * DONE_DLY + 8);
        chk("R8 two commands", n_acc - base, 2);
        chk("R8 follow-up carries latest", last_acc, 16'h0200);
        rd(A_STS, r); chk("R8 overlap and completed set", r, 16'h8010);
        wr(A_STS, 16'h8010);
        rd(A_STS, r); chk("R8 overlap cleared", r, 16'h0000);
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule